// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical address by reading up to three page table entries from memory, one per level. A translation request carries the virtual address and a flag that says whether the access comes from user mode. The walk starts from the table whose physical address sits in the page table base input. Each level consumes one index field of the virtual page number. The walk stops at the first entry that is not marked valid.

A valid leaf gives the physical page number. That number, joined with the untouched page offset, forms the result, together with the leaf's low flag byte. A user-mode request that reaches a leaf without the user-accessible flag is refused with a protection fault. The block runs one walk at a time. It talks to memory through a single read port: the request is held until the response arrives.

Top module: `ptw_walker`

## Requirements
- R1: While reset is low and in the first cycle after it, `busy`, `done`, `fault` and `mem_req` are all low.
- R2: A request is accepted when `req_valid` is high and `busy` is low. From the next cycle `busy` and `mem_req` are high, with `mem_addr` = (`ptbr` with its low K bits cleared) + 8 × first index. A `req_valid` seen while `busy` is high is ignored.
- R3: With K offset bits and I bits per index, the first index is vaddr[K+3I-1:K+2I], the second is vaddr[K+2I-1:K+I] and the third is vaddr[K+I-1:K]. The entry for levels 2 and 3 is read at (PPN of the previous entry << K) + 8 × index. An entry has its valid flag at bit 0, its user flag at bit 1 and its PPN at bits [10 +: PA_W-K].
- R4: `mem_req` stays high with a stable `mem_addr` until `mem_rsp_valid` is seen. Only one read is outstanding, and `mem_req` is only high while `busy` is high.
- R5: An entry with bit 0 clear at level L (1..3) ends the walk. The next cycle shows `fault` with `fault_cause` = 2'b01 and `fault_level` = L, `mem_req` is low, and no further read follows.
- R6: A valid third-level entry that passes the privilege check gives `done`, with `pa` = {leaf PPN, vaddr[K-1:0]} and `meta` = leaf bits [7:0].
- R7: A user-mode request whose valid leaf has bit 1 clear gives `fault` with `fault_cause` = 2'b10 and `fault_level` = 3. A supervisor-mode request translates the same leaf normally.
- R8: `done` and `fault` are each high for exactly one cycle, never together, and `busy` is low in that cycle. `busy` stays high from acceptance until then.
- R9: The user flag of first- and second-level entries has no effect on the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_user | input | 1 | Request comes from user mode |
| ptbr | input | PA_W | Physical address of the first-level table |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Entry read request, held until response |
| mem_addr | output | PA_W | Physical address of the entry being read |
| mem_rsp_valid | input | 1 | Entry data valid this cycle |
| mem_rsp_data | input | PTE_W | Entry read from memory |
| done | output | 1 | One-cycle translation complete pulse |
| pa | output | PA_W | Translated physical address |
| meta | output | 8 | Flag byte of the leaf entry |
| fault | output | 1 | One-cycle fault pulse |
| fault_cause | output | 2 | 01 not valid, 10 protection |
| fault_level | output | 2 | Level (1..3) where the walk stopped |

## Verification
The hardest cases to reach are the stop points deep in a walk. These are an invalid third-level entry and a protection refusal, and both only appear after two earlier reads have succeeded through tables the walk chose itself. The bench holds a sparse memory and lays out linked tables for it. Some chains break at each level, one leaf lacks the user flag, and one chain has intermediate entries without the user flag. The bench answers reads after varying delays and presents decoy requests while a read is pending.

// File: rtl/ptw_pkg.sv
// Shared constants and types of the page table walker.
// Assumes the entry layout: valid at bit 0, user at bit 1, PPN from bit 10.
package ptw_pkg;
    localparam int PTE_V_BIT   = 0;
    localparam int PTE_U_BIT   = 1;
    localparam int PTE_PPN_LSB = 10;
    localparam int META_W      = 8;
    localparam int ENT_SHIFT   = 3;  // 8-byte entries

    localparam logic [1:0] CAUSE_INVALID = 2'b01;
    localparam logic [1:0] CAUSE_PROT    = 2'b10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_t;
endpackage

// File: rtl/ptw_index_sel.sv
// Picks the index field for a level and forms the entry's physical address.
// Assumes level is 1..3; level 1 takes the most significant field.
module ptw_index_sel #(
    parameter int K     = 12,
    parameter int IDX_W = 9,
    parameter int PA_W  = 40,
    localparam int VA_W  = K + 3 * IDX_W,
    localparam int PPN_W = PA_W - K
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [1:0]       level,
    input  logic [PPN_W-1:0] base_ppn,
    output logic [PA_W-1:0]  entry_addr
);
    import ptw_pkg::*;

    logic [IDX_W-1:0] field [3];
    logic [IDX_W-1:0] idx;

    // Slice the three index fields out of the virtual page number.
    for (genvar g = 0; g < 3; g++) begin : g_field
        assign field[g] = vaddr[K + (2 - g) * IDX_W +: IDX_W];
    end

    // Select the field for the current level and add its scaled offset to the table base.
    always_comb begin
        case (level)
            2'd1:    idx = field[0];
            2'd2:    idx = field[1];
            default: idx = field[2];
        endcase
        entry_addr = {base_ppn, {K{1'b0}}}
                   + ({{(PA_W - IDX_W){1'b0}}, idx} << ENT_SHIFT);
    end
endmodule

// File: rtl/ptw_pte_check.sv
// Decodes one entry: next PPN, flag byte, and whether the walk may go on.
// Assumes the user flag matters only at the leaf level.
module ptw_pte_check #(
    parameter int PTE_W = 64,
    parameter int PPN_W = 28
) (
    input  logic [PTE_W-1:0]       pte,
    input  logic                   is_leaf,
    input  logic                   user_req,
    output logic [PPN_W-1:0]       next_ppn,
    output logic [ptw_pkg::META_W-1:0] meta,
    output logic                   ok,
    output logic [1:0]             cause
);
    import ptw_pkg::*;

    // Classify the entry as usable, not valid, or refused for privilege.
    always_comb begin
        next_ppn = pte[PTE_PPN_LSB +: PPN_W];
        meta     = pte[META_W-1:0];
        ok       = 1'b0;
        cause    = 2'b00;
        if (!pte[PTE_V_BIT]) begin
            cause = CAUSE_INVALID;
        end else if (is_leaf && user_req && !pte[PTE_U_BIT]) begin
            cause = CAUSE_PROT;
        end else begin
            ok = 1'b1;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
// Three-level page table walker: one walk at a time, one entry read per level.
// Assumes memory holds mem_rsp_valid low unless answering the pending read.
module ptw_walker #(
    parameter int K     = 12,
    parameter int IDX_W = 9,
    parameter int PA_W  = 40,
    parameter int PTE_W = 64,
    localparam int VA_W  = K + 3 * IDX_W,
    localparam int PPN_W = PA_W - K
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_user,
    input  logic [PA_W-1:0]  ptbr,
    output logic             busy,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done,
    output logic [PA_W-1:0]  pa,
    output logic [7:0]       meta,
    output logic             fault,
    output logic [1:0]       fault_cause,
    output logic [1:0]       fault_level
);
    import ptw_pkg::*;

    walk_state_t       state;
    logic [1:0]        level;
    logic [VA_W-1:0]   va_q;
    logic              user_q;

    logic [VA_W-1:0]   sel_va;
    logic [1:0]        sel_level;
    logic [PPN_W-1:0]  sel_base;
    logic [PA_W-1:0]   sel_addr;

    logic [PPN_W-1:0]  chk_ppn;
    logic [META_W-1:0] chk_meta;
    logic              chk_ok;
    logic [1:0]        chk_cause;

    // Route either the new request or the entry just returned into the address former.
    always_comb begin
        if (state == ST_IDLE) begin
            sel_va    = req_vaddr;
            sel_level = 2'd1;
            sel_base  = ptbr[PA_W-1:K];
        end else begin
            sel_va    = va_q;
            sel_level = level + 2'd1;
            sel_base  = chk_ppn;
        end
    end

    ptw_index_sel #(.K(K), .IDX_W(IDX_W), .PA_W(PA_W)) u_index (
        .vaddr      (sel_va),
        .level      (sel_level),
        .base_ppn   (sel_base),
        .entry_addr (sel_addr)
    );

    ptw_pte_check #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_check (
        .pte      (mem_rsp_data),
        .is_leaf  (level == 2'd3),
        .user_req (user_q),
        .next_ppn (chk_ppn),
        .meta     (chk_meta),
        .ok       (chk_ok),
        .cause    (chk_cause)
    );

    assign busy = (state == ST_WALK);

    // Walk sequencing: accept, read each level, then pulse done or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            level       <= 2'd0;
            va_q        <= '0;
            user_q      <= 1'b0;
            mem_req     <= 1'b0;
            mem_addr    <= '0;
            done        <= 1'b0;
            fault       <= 1'b0;
            fault_cause <= 2'b00;
            fault_level <= 2'd0;
            pa          <= '0;
            meta        <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state    <= ST_WALK;
                        level    <= 2'd1;
                        va_q     <= req_vaddr;
                        user_q   <= req_user;
                        mem_req  <= 1'b1;
                        mem_addr <= sel_addr;
                    end
                end
                default: begin
                    if (mem_rsp_valid) begin
                        if (!chk_ok) begin
                            state       <= ST_IDLE;
                            mem_req     <= 1'b0;
                            fault       <= 1'b1;
                            fault_cause <= chk_cause;
                            fault_level <= level;
                        end else if (level == 2'd3) begin
                            state   <= ST_IDLE;
                            mem_req <= 1'b0;
                            done    <= 1'b1;
                            pa      <= {chk_ppn, va_q[K-1:0]};
                            meta    <= chk_meta;
                        end else begin
                            level    <= level + 2'd1;
                            mem_addr <= sel_addr;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
// Protocol checker for the walker; observes ports only.
// Assumes it is bound to ptw_walker with matching parameters.
module ptw_walker_chk #(
    parameter int PA_W = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_rsp_valid,
    input logic            done,
    input logic            fault,
    input logic [1:0]      fault_cause,
    input logic [1:0]      fault_level
);
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy |=> busy && mem_req);

    assert_hold_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr));

    assert_req_in_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_stop_on_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_req && (fault_cause == 2'b01 || fault_cause == 2'b10)
                  && fault_level != 2'd0);

    assert_prot_at_leaf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault && fault_cause == 2'b10 |-> fault_level == 2'd3);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault) && !(busy && (done || fault)));

    assert_end_follows_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> $past(mem_rsp_valid));
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .fault         (fault),
    .fault_cause   (fault_cause),
    .fault_level   (fault_level)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    localparam int K = 12, IDX_W = 9, PA_W = 40, PTE_W = 64;
    localparam int VA_W = K + 3 * IDX_W;
    localparam int PPN_W = PA_W - K;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_user = 0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic [PA_W-1:0] ptbr = '0;
    logic busy, mem_req, done, fault;
    logic [PA_W-1:0] mem_addr, pa;
    logic mem_rsp_valid = 0;
    logic [PTE_W-1:0] mem_rsp_data = '0;
    logic [7:0] meta;
    logic [1:0] fault_cause, fault_level;

    int total = 0, bad = 0;

    always #10 clk = ~clk;

    ptw_walker #(.K(K), .IDX_W(IDX_W), .PA_W(PA_W), .PTE_W(PTE_W)) u_dut (.*);

    // Behavioural memory and expected results.
    logic [PTE_W-1:0] pmem [logic [PA_W-1:0]];
    logic [PA_W-1:0] e_addr [3];
    int e_n;
    bit e_fault;
    logic [1:0] e_cause, e_lvl;
    logic [PA_W-1:0] e_pa;
    logic [7:0] e_meta;

    task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [PTE_W-1:0] rd(logic [PA_W-1:0] a);
        if (pmem.exists(a)) return pmem[a];
        return '0;
    endfunction

    task automatic put(logic [PA_W-1:0] tbl_ppn, int idx, logic [PPN_W-1:0] ppn,
                       bit v, bit u, logic [7:0] flags);
        logic [PTE_W-1:0] e = '0;
        e[7:0] = flags;
        e[0] = v;
        e[1] = u;
        e[10 +: PPN_W] = ppn;
        pmem[(tbl_ppn << K) + PA_W'(idx * 8)] = e;
    endtask

    function automatic logic [VA_W-1:0] mkva(int i1, int i2, int i3, int off);
        return {IDX_W'(i1), IDX_W'(i2), IDX_W'(i3), K'(off)};
    endfunction

    // Reference walk computed from the requirements.
    task automatic model(logic [VA_W-1:0] va, bit user);
        logic [PPN_W-1:0] ppn = ptbr[PA_W-1:K];
        e_fault = 0;
        for (int l = 1; l <= 3; l++) begin
            logic [IDX_W-1:0] idx = va[K + (3 - l) * IDX_W +: IDX_W];
            logic [PA_W-1:0] a = {ppn, {K{1'b0}}} + PA_W'(idx) * 8;
            logic [PTE_W-1:0] e = rd(a);
            e_addr[l-1] = a;
            e_n = l;
            if (!e[0]) begin
                e_fault = 1; e_cause = 2'b01; e_lvl = 2'(l);
                return;
            end
            if (l == 3) begin
                if (user && !e[1]) begin
                    e_fault = 1; e_cause = 2'b10; e_lvl = 2'd3;
                end else begin
                    e_pa = {e[10 +: PPN_W], va[K-1:0]};
                    e_meta = e[7:0];
                end
                return;
            end
            ppn = e[10 +: PPN_W];
        end
    endtask

    task automatic walk(logic [VA_W-1:0] va, bit user, int seed, string rq);
        model(va, user);
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_user = user;
        @(negedge clk);
        req_valid = 0;
        chk(busy === 1'b1, "R8", "busy after accept", 64'(busy), 1);
        for (int r = 0; r < e_n; r++) begin
            int lat = (r + seed) % 3;
            chk(mem_req === 1'b1, "R2", "mem_req", 64'(mem_req), 1);
            chk(mem_addr === e_addr[r], "R3", "entry addr", 64'(mem_addr), 64'(e_addr[r]));
            for (int w = 0; w < lat; w++) begin
                req_valid = 1; req_vaddr = ~va; req_user = ~user;  // decoy, R2
                @(negedge clk);
                chk(mem_req === 1'b1 && mem_addr === e_addr[r], "R4", "held read",
                    64'(mem_addr), 64'(e_addr[r]));
                chk(busy === 1'b1 && !done && !fault, "R8", "busy during walk", 64'(busy), 1);
            end
            req_valid = 0;
            mem_rsp_valid = 1; mem_rsp_data = rd(e_addr[r]);
            @(negedge clk);
            mem_rsp_valid = 0; mem_rsp_data = '0;
        end
        chk(busy === 1'b0 && mem_req === 1'b0, "R5", "stopped after last read",
            64'({busy, mem_req}), 0);
        if (e_fault) begin
            chk(fault === 1'b1 && done === 1'b0, rq, "fault pulse", 64'({fault, done}), 2);
            chk(fault_cause === e_cause && fault_level === e_lvl, rq, "cause/level",
                64'({fault_cause, fault_level}), 64'({e_cause, e_lvl}));
        end else begin
            chk(done === 1'b1 && fault === 1'b0, rq, "done pulse", 64'({done, fault}), 2);
            chk(pa === e_pa, rq, "pa", 64'(pa), 64'(e_pa));
            chk(meta === e_meta, rq, "meta", 64'(meta), 64'(e_meta));
        end
        @(negedge clk);
        chk(!done && !fault && !busy && !mem_req, "R8", "single pulse, decoy ignored",
            64'({done, fault, busy, mem_req}), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Tables: root at PPN 1.
        put(1, 3, 2, 1, 1, 8'h00);
        put(2, 5, 3, 1, 1, 8'h00);
        put(3, 7, 28'h1234567, 1, 1, 8'hC3);
        put(3, 8, 28'h0ABCDEF, 1, 0, 8'h55);
        put(1, 10, 4, 1, 0, 8'h00);
        put(4, 0, 5, 1, 0, 8'h00);
        put(5, 511, 28'hFFFFFFF, 1, 1, 8'h7B);
        put(6, 3, 2, 1, 1, 8'h00);
        ptbr = 40'h0000001000;

        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !mem_req, "R1", "in reset",
            64'({busy, done, fault, mem_req}), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !fault && !mem_req, "R1", "after reset",
            64'({busy, done, fault, mem_req}), 0);

        walk(mkva(3, 5, 7, 12'hABC), 0, 0, "R6");
        walk(mkva(3, 5, 7, 12'h001), 1, 1, "R6");
        walk(mkva(3, 5, 8, 12'h123), 1, 2, "R7");
        walk(mkva(3, 5, 8, 12'hFFF), 0, 0, "R7");
        walk(mkva(4, 5, 7, 12'h000), 0, 1, "R5");
        walk(mkva(3, 6, 7, 12'h000), 1, 2, "R5");
        walk(mkva(3, 5, 9, 12'h010), 0, 0, "R5");
        walk(mkva(10, 0, 511, 12'hFFF), 1, 1, "R9");
        ptbr = 40'h0000006000;
        walk(mkva(3, 5, 7, 12'h456), 0, 2, "R3");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule